// File: doc/BRIEF.md
# Paired-Channel PWM Generator

Two pulse-width-modulated outputs are produced from one pair of channels that share a clock setup. The shared setup chooses which of two incoming tick streams (an oscillator tick or a bus tick, both single-cycle enable pulses in the system clock domain) feeds the pair, and slows it by a power of two. Each channel then applies its own 8-bit prescaler and runs a period counter. It compares that counter against an active count to produce the output waveform.

Software-style register writes arrive over a simple synchronous port: one write strobe, an address, a 32-bit write word and a registered read word. Period and prescaler values are staged in shadow storage and only reach the running counters at a period boundary, so a waveform never shows a torn period. A per-channel bypass routes the divided source clock, as a square wave, straight to the pin.

Top module: `pwm_pair_top`

## Requirements
- R1: The pair counts only on ticks from the source picked by bit 0 of address 0 (0 = `osc_tick`, 1 = `bus_tick`); pulses on the other input have no effect on the outputs.
- R2: Bits 4:1 of address 0 hold an exponent M; the selected tick rate is divided by 2^M, and any M above 8 acts as 8.
- R3: Address 2+2c holds channel c's prescaler K in bits 7:0; each period step lasts K+1 divided ticks.
- R4: Address 3+2c holds the period length E in bits 15:0 and the active count A in bits 31:16; one output period lasts E+1 period steps.
- R5: The output is at its active level for the first A steps of each period, and for the whole period when A is at least E+1.
- R6: With A = 0 the output never reaches its active level.
- R7: Bit 8 of address 2+2c selects the active level: 1 means active high, 0 means active low.
- R8: Address 1 bit c is channel c's enable and bit 2+c its clock gate; unless both are set the channel's counters are held at zero and its output sits at the inactive level.
- R9: Address 1 bit 4+c is channel c's bypass; with the channel running and bypass set, the output is a square wave that starts low and toggles on every divided tick.
- R10: A period or prescaler write made while a channel runs takes effect at the next period boundary; while a channel is stopped it takes effect at once.
- R11: The read word, one cycle after an address is presented, returns the last value written to that address in the field layout above, with unused bits zero.
- R12: After reset every register is zero, so both outputs sit at the inactive level of active-low polarity (high) and every read returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Oscillator tick enable pulse |
| bus_tick | input | 1 | Bus tick enable pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write word |
| reg_rdata | output | 32 | Registered read word for the address of the previous cycle |
| pwm_out | output | 2 | Channel outputs, bit c for channel c |

## Verification
A register write lands on the clock edge that samples the strobe, and the outputs are decoded combinationally from counter state, so the first waveform cycle after an enable write is visible in the very cycle that follows that edge; the read word trails its address by exactly one edge. The bench drives and samples only on falling edges, opens every measurement window on the sample right after the enabling write, and sizes each window to two whole periods of (K+1)·(E+1)·2^M cycles, so active-cycle counts are exact rather than approximate. The shadow test injects its write a fixed number of cycles into a running period and expects the old active count to finish that period before the new one applies.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    localparam int unsigned CNT_W  = 16;
    localparam int unsigned PRE_W  = 8;
    localparam int unsigned DIVM_W = 4;
    localparam int unsigned DATA_W = 2 * CNT_W;

    // Per-channel settings as seen by a channel engine
    typedef struct packed {
        logic             act_hi;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] ent;
        logic [CNT_W-1:0] act;
    } chan_cfg_t;

endpackage

// File: rtl/pwm_pair_regs.sv
module pwm_pair_regs
    import pwm_pair_pkg::*;
#(
    parameter int unsigned NCH    = 2,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic                  src_sel,
    output logic [DIVM_W-1:0]     div_m,
    output logic [NCH-1:0]        en,
    output logic [NCH-1:0]        gate,
    output logic [NCH-1:0]        byp,
    output chan_cfg_t [NCH-1:0]   cfg,
    output logic [DATA_W-1:0]     rdata
);

    typedef struct packed {
        logic                 src;
        logic [DIVM_W-1:0]    divm;
        logic [NCH-1:0]       en;
        logic [NCH-1:0]       gate;
        logic [NCH-1:0]       byp;
        chan_cfg_t [NCH-1:0]  ch;
        logic [DATA_W-1:0]    rdata;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        // read path: registered view of the addressed register
        r_d.rdata = '0;
        if (addr == ADDR_W'(0)) begin
            r_d.rdata = DATA_W'({r_q.divm, r_q.src});
        end
        if (addr == ADDR_W'(1)) begin
            r_d.rdata = DATA_W'({r_q.byp, r_q.gate, r_q.en});
        end
        for (int c = 0; c < NCH; c++) begin
            if (addr == ADDR_W'(2 + 2 * c)) begin
                r_d.rdata = DATA_W'({r_q.ch[c].act_hi, r_q.ch[c].pre});
            end
            if (addr == ADDR_W'(3 + 2 * c)) begin
                r_d.rdata = {r_q.ch[c].act, r_q.ch[c].ent};
            end
        end
        // write path
        if (wr_en) begin
            if (addr == ADDR_W'(0)) begin
                r_d.src  = wdata[0];
                r_d.divm = wdata[DIVM_W:1];
            end
            if (addr == ADDR_W'(1)) begin
                r_d.en   = wdata[NCH-1:0];
                r_d.gate = wdata[2*NCH-1:NCH];
                r_d.byp  = wdata[3*NCH-1:2*NCH];
            end
            for (int c = 0; c < NCH; c++) begin
                if (addr == ADDR_W'(2 + 2 * c)) begin
                    r_d.ch[c].pre    = wdata[PRE_W-1:0];
                    r_d.ch[c].act_hi = wdata[PRE_W];
                end
                if (addr == ADDR_W'(3 + 2 * c)) begin
                    r_d.ch[c].ent = wdata[CNT_W-1:0];
                    r_d.ch[c].act = wdata[DATA_W-1:CNT_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign src_sel = r_q.src;
    assign div_m   = r_q.divm;
    assign en      = r_q.en;
    assign gate    = r_q.gate;
    assign byp     = r_q.byp;
    assign cfg     = r_q.ch;
    assign rdata   = r_q.rdata;

    // R11: a run-control write is visible on the control outputs one edge later
    p_ctrl_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(1)) |=> (en == $past(wdata[NCH-1:0])));

endmodule

// File: rtl/pwm_pair_div.sv
module pwm_pair_div
    import pwm_pair_pkg::*;
#(
    parameter int unsigned MAX_DIVM = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              bus_tick,
    input  logic              src_sel,
    input  logic [DIVM_W-1:0] div_m,
    input  logic              active,
    output logic              div_tick,
    output logic              div_lvl
);

    localparam int unsigned CB = (MAX_DIVM > 0) ? MAX_DIVM : 1;

    typedef struct packed {
        logic [CB-1:0] cnt;
        logic          lvl;
    } div_t;

    div_t        d_d, d_q;
    logic        src_tick;
    logic [CB-1:0] mask;
    int unsigned m_eff;

    always_comb begin
        m_eff    = (32'(div_m) > MAX_DIVM) ? MAX_DIVM : 32'(div_m);
        mask     = CB'((32'd1 << m_eff) - 32'd1);
        src_tick = src_sel ? bus_tick : osc_tick;
        div_tick = active && src_tick && (d_q.cnt >= mask);
        d_d      = d_q;
        if (!active) begin
            d_d.cnt = '0;
            d_d.lvl = 1'b0;
        end else if (src_tick) begin
            if (d_q.cnt >= mask) begin
                d_d.cnt = '0;
                d_d.lvl = ~d_q.lvl;
            end else begin
                d_d.cnt = d_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign div_lvl = d_q.lvl;

    // R2: an idle pair restarts its divider from zero
    p_idle_divider_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (d_q.cnt == '0 && !d_q.lvl));

    // R9: the bypass square wave flips on every divided tick
    p_lvl_flips_r9: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick |=> (d_q.lvl != $past(d_q.lvl)));

endmodule

// File: rtl/pwm_pair_chan.sv
module pwm_pair_chan
    import pwm_pair_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  logic      byp,
    input  logic      div_tick,
    input  logic      div_lvl,
    input  chan_cfg_t cfg,
    output logic      pwm_o
);

    typedef struct packed {
        logic [PRE_W-1:0] pre_cnt;
        logic [CNT_W-1:0] per_cnt;
        logic [PRE_W-1:0] cur_pre;
        logic [CNT_W-1:0] cur_ent;
        logic [CNT_W-1:0] cur_act;
    } chan_t;

    chan_t s_d, s_q;
    logic  on_phase;

    always_comb begin
        s_d = s_q;
        if (!run || byp) begin
            // stopped: clear counters and take shadow values at once
            s_d.pre_cnt = '0;
            s_d.per_cnt = '0;
            s_d.cur_pre = cfg.pre;
            s_d.cur_ent = cfg.ent;
            s_d.cur_act = cfg.act;
        end else if (div_tick) begin
            if (s_q.pre_cnt >= s_q.cur_pre) begin
                s_d.pre_cnt = '0;
                if (s_q.per_cnt >= s_q.cur_ent) begin
                    // period boundary: shadow values become live
                    s_d.per_cnt = '0;
                    s_d.cur_pre = cfg.pre;
                    s_d.cur_ent = cfg.ent;
                    s_d.cur_act = cfg.act;
                end else begin
                    s_d.per_cnt = s_q.per_cnt + 1'b1;
                end
            end else begin
                s_d.pre_cnt = s_q.pre_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        on_phase = s_q.per_cnt < s_q.cur_act;
        if (!run) begin
            pwm_o = ~cfg.act_hi;
        end else if (byp) begin
            pwm_o = div_lvl;
        end else begin
            pwm_o = cfg.act_hi ? on_phase : ~on_phase;
        end
    end

    // R4: the period counter never passes the live period length
    p_cnt_in_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !byp) |-> (s_q.per_cnt <= s_q.cur_ent));

    // R3: without a divided tick the period counter holds
    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !byp && !div_tick) |=> $stable(s_q.per_cnt));

    // R8: a stopped channel has cleared counters on the next cycle
    p_idle_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (s_q.per_cnt == '0 && s_q.pre_cnt == '0));

    // R5: active count beyond the period length gives a constant active level
    p_full_duty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !byp && (s_q.cur_act > s_q.cur_ent)) |-> (pwm_o == cfg.act_hi));

    // R6: a zero active count gives a constant inactive level
    p_zero_duty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !byp && s_q.cur_act == '0) |-> (pwm_o == !cfg.act_hi));

    // R10: live active count changes only at a period boundary while counting
    p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !byp && s_q.per_cnt != s_q.cur_ent) |=> $stable(s_q.cur_act));

endmodule

// File: rtl/pwm_pair_top.sv
module pwm_pair_top
    import pwm_pair_pkg::*;
#(
    parameter int unsigned NCH      = 2,
    parameter int unsigned MAX_DIVM = 8,
    localparam int unsigned ADDR_W  = $clog2(2 + 2 * NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              bus_tick,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NCH-1:0]    pwm_out
);

    logic                 src_sel;
    logic [DIVM_W-1:0]    div_m;
    logic [NCH-1:0]       en;
    logic [NCH-1:0]       gate;
    logic [NCH-1:0]       byp;
    logic [NCH-1:0]       run;
    chan_cfg_t [NCH-1:0]  cfg;
    logic                 div_tick;
    logic                 div_lvl;

    pwm_pair_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .src_sel (src_sel),
        .div_m   (div_m),
        .en      (en),
        .gate    (gate),
        .byp     (byp),
        .cfg     (cfg),
        .rdata   (reg_rdata)
    );

    assign run = en & gate;

    pwm_pair_div #(.MAX_DIVM(MAX_DIVM)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .bus_tick (bus_tick),
        .src_sel  (src_sel),
        .div_m    (div_m),
        .active   (|run),
        .div_tick (div_tick),
        .div_lvl  (div_lvl)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pwm_pair_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run[c]),
            .byp      (byp[c]),
            .div_tick (div_tick),
            .div_lvl  (div_lvl),
            .cfg      (cfg[c]),
            .pwm_o    (pwm_out[c])
        );
    end

endmodule

// File: tb/tb_pwm_pair_top.sv
module tb_pwm_pair_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b0;
    logic        bus_tick = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  pwm_out;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pwm_pair_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_tick  (osc_tick),
        .bus_tick  (bus_tick),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    typedef struct packed {
        logic        ch;
        logic        src;
        logic [3:0]  m;
        logic [7:0]  k;
        logic [15:0] e;
        logic [15:0] a;
        logic        pol;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 4'd0,  8'd0, 16'd9,  16'd3,   1'b1},
        '{1'b1, 1'b0, 4'd1,  8'd1, 16'd4,  16'd2,   1'b1},
        '{1'b0, 1'b1, 4'd0,  8'd2, 16'd3,  16'd4,   1'b1},
        '{1'b1, 1'b1, 4'd2,  8'd0, 16'd5,  16'd0,   1'b1},
        '{1'b0, 1'b0, 4'd0,  8'd0, 16'd7,  16'd100, 1'b0},
        '{1'b1, 1'b0, 4'd0,  8'd3, 16'd2,  16'd1,   1'b0},
        '{1'b0, 1'b0, 4'd3,  8'd0, 16'd1,  16'd1,   1'b1},
        '{1'b1, 1'b0, 4'd15, 8'd0, 16'd1,  16'd1,   1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input int a, input logic [31:0] d);
        reg_we    = 1'b1;
        reg_addr  = 3'(a);
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic count_high(input int ch, input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out[ch]) hi++;
            @(negedge clk);
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int hi;
        int mism;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk("R12 outputs idle high", int'(pwm_out), 3);
        reg_addr = 3'd3;
        @(negedge clk);
        chk("R12 period reads zero", int'(reg_rdata), 0);

        // R11: read back
        wr(3, 32'hABCD_1234);
        @(negedge clk);
        chk("R11 period readback", int'(reg_rdata), int'(32'hABCD_1234));
        wr(0, 32'h0000_000B);
        @(negedge clk);
        chk("R11 clock config readback", int'(reg_rdata), 11);

        // Vector table: R1 R2 R3 R4 R5 R6 R7
        for (int v = 0; v < 8; v++) begin
            int ch, mm, tk, per, aa, win, act_cnt, exp_hi;
            ch  = int'(VECS[v].ch);
            mm  = (VECS[v].m > 4'd8) ? 8 : int'(VECS[v].m);
            tk  = (1 << mm) * (int'(VECS[v].k) + 1);
            per = tk * (int'(VECS[v].e) + 1);
            aa  = (int'(VECS[v].a) > int'(VECS[v].e) + 1) ? int'(VECS[v].e) + 1 : int'(VECS[v].a);
            win = 2 * per;
            act_cnt = 2 * tk * aa;
            exp_hi  = VECS[v].pol ? act_cnt : win - act_cnt;
            wr(1, 32'h0);
            osc_tick = !VECS[v].src;
            bus_tick = VECS[v].src;
            wr(0, {27'd0, VECS[v].m, VECS[v].src});
            wr(2 + 2 * ch, {23'd0, VECS[v].pol, VECS[v].k});
            wr(3 + 2 * ch, {VECS[v].a, VECS[v].e});
            wr(1, 32'(1 << ch) | 32'(1 << (ch + 2)));
            count_high(ch, win, hi);
            chk($sformatf("R2 R3 R4 R5 R6 R7 vector %0d high cycles", v), hi, exp_hi);
        end

        // R1: ticks only on the unselected source leave the counter frozen
        wr(1, 32'h0);
        osc_tick = 1'b1;
        bus_tick = 1'b0;
        wr(0, 32'h1);
        wr(2, 32'h100);
        wr(3, {16'd1, 16'd3});
        wr(1, 32'h5);
        count_high(0, 8, hi);
        chk("R1 unselected source ignored", hi, 8);

        // R8: enable without gate keeps the output inactive
        wr(1, 32'h0);
        wr(0, 32'h0);
        wr(3, {16'd2, 16'd3});
        wr(1, 32'h1);
        count_high(0, 10, hi);
        chk("R8 enable without gate", hi, 0);
        wr(1, 32'h5);
        chk("R8 running starts active", int'(pwm_out[0]), 1);
        wr(1, 32'h4);
        chk("R8 gate without enable", int'(pwm_out[0]), 0);

        // R9: bypass square wave, divided by 2
        wr(1, 32'h0);
        wr(0, 32'h2);
        wr(4, 32'h100);
        wr(1, 32'h2A);
        mism = 0;
        for (int i = 0; i < 8; i++) begin
            if (int'(pwm_out[1]) != ((i >> 1) & 1)) mism++;
            @(negedge clk);
        end
        chk("R9 bypass waveform mismatches", mism, 0);

        // R10: shadowed period write mid-period
        wr(1, 32'h0);
        wr(0, 32'h0);
        wr(2, 32'h100);
        wr(3, {16'd5, 16'd9});
        wr(1, 32'h5);
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            if (pwm_out[0]) hi++;
            if (i == 2) begin
                reg_we    = 1'b1;
                reg_addr  = 3'd3;
                reg_wdata = {16'd1, 16'd9};
            end else begin
                reg_we = 1'b0;
            end
            @(negedge clk);
        end
        reg_we = 1'b0;
        chk("R10 write waits for period boundary", hi, 6);

        summary();
        $finish;
    end

endmodule